// File: doc/BRIEF.md
# Master Request Retry Controller

This block sits on the master side of a half-duplex command link shared by many slaves. When asked to address a slave, it launches one request frame, waits for the transmitter to report the frame as sent, and then opens a fixed response window. The window is 2 ms by default and is counted in clock cycles derived from the clock-frequency parameter. A valid reply carrying the addressed slave's identifier closes the transaction successfully. If the window runs out with no such reply, the same request is sent again and a fresh window follows.

Slaves speak only when spoken to, so a reply is expected only after a request. A slave that stays silent through a set number of consecutive sends (five by default) is marked as not working. The master has no way to revive a slave, so the mark lasts until the block itself is reset. Requests to a marked slave finish at once as failures and put nothing on the line. The default five windows of 2 ms each fit within the 20 ms budget for a complete exchange.

The block does not format frames and does not drive the modem. It issues a start pulse with a target identifier, and it accepts a frame-sent strobe and a reply strobe from the neighbouring logic.

Top module: `poll_retry_ctrl`

## Requirements
- R1: After reset, `busy`, `txStart` and `done` are low and every bit of `deadFlags` is 0.
- R2: A request (`reqValid` high while `busy` is low) aimed at a slave whose dead flag is 0 raises `txStart` for exactly one cycle, in the cycle after the request is sampled, with `txId` equal to the requested identifier. `busy` is high from that cycle on.
- R3: A reply (`rxValid` high with `rxId` equal to `txId`) sampled inside the response window ends the transaction. In the next cycle `done` is 1, `success` is 1 and `busy` is 0.
- R4: If the window ends with no matching reply and fewer than `MAX_SENDS` sends have been made, `txStart` pulses again with the same `txId`. A new window opens after the next `txDone`.
- R5: After `MAX_SENDS` consecutive sends with no matching reply, the block reports `done`=1 and `success`=0 in the cycle after the last window ends, and `deadFlags[id]` becomes 1. Bit i of `deadFlags` belongs to identifier i. Only reset clears a dead flag.
- R6: A request aimed at a slave whose dead flag is set produces no `txStart`. `busy` stays low, and in the next cycle `done`=1 and `success`=0.
- R7: A request sampled while `busy` is high is ignored. `txId` does not change and no extra `txStart` appears.
- R8: `rxValid` is ignored when `rxId` differs from `txId`, and at any time outside the response window, including before `txDone` is seen.
- R9: A matching reply sampled in the last cycle of the window counts as success. A reply that arrives one cycle after the window has expired is ignored.
- R10: The window lasts WIN_CYC = CLK_HZ*WINDOW_US/1,000,000 cycles, starting in the cycle after `txDone` is sampled. On a timeout, the resend `txStart` is visible exactly WIN_CYC cycles after the first window cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request to start a transaction |
| reqId | input | ID_W | Identifier of the slave to address |
| txDone | input | 1 | Strobe from the transmitter: the frame has been sent |
| rxValid | input | 1 | Strobe from the receiver: a valid reply frame has arrived |
| rxId | input | ID_W | Identifier carried by the reply |
| txStart | output | 1 | One-cycle pulse that tells the transmitter to send a request |
| txId | output | ID_W | Identifier of the current target |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle pulse marking the end of a transaction |
| success | output | 1 | Outcome of the transaction, valid while `done` is high |
| deadFlags | output | 2**ID_W | One flag per slave, set once that slave is declared not working |

## Verification
The hardest situations to reach are the boundaries of the response window and the fifth consecutive silent window. A reply in exactly the last cycle of a window must be accepted, and a reply one cycle later must be ignored. The bench acts as both the transmitter and the replying slave. It drives `txDone` itself and counts falling edges from the first window cycle, so it can place replies at exact offsets and withhold them through every retry until the slave is declared dead. A behavioural model running beside the design checks every output on every cycle.

// File: rtl/poll_retry_pkg.sv
package poll_retry_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LAUNCH  = 2'd1,
    PH_TXWAIT  = 2'd2,
    PH_RSPWAIT = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTarget;
    logic clrWin;
    logic incWin;
    logic bumpSend;
    logic markDead;
    logic finishOk;
    logic finishFail;
  } ctrlStrobes_t;

  // conditions from datapath to control
  typedef struct packed {
    logic reqDead;
    logic rspHit;
    logic winLast;
    logic sendLast;
  } dpStatus_t;

endpackage

// File: rtl/poll_retry_dp.sv
module poll_retry_dp
  import poll_retry_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int WIN_CYC   = 200000,
  parameter int MAX_SENDS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [ID_W-1:0]      reqId,
  input  logic                 rxValid,
  input  logic [ID_W-1:0]      rxId,
  output dpStatus_t            stat,
  output logic [ID_W-1:0]      targetId,
  output logic [(1<<ID_W)-1:0] deadVec,
  output logic                 doneQ,
  output logic                 successQ
);

  localparam int NUM_SLAVES = 1 << ID_W;
  localparam int WIN_W      = $clog2(WIN_CYC + 1);
  localparam int SEND_W     = $clog2(MAX_SENDS + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYC - 1);
  localparam logic [SEND_W-1:0] SEND_LAST = SEND_W'(MAX_SENDS - 1);

  logic [WIN_W-1:0]  winCnt;
  logic [SEND_W-1:0] sendCnt;

  always_comb begin
    stat.reqDead  = deadVec[reqId];
    stat.rspHit   = rxValid && (rxId == targetId);
    stat.winLast  = (winCnt == WIN_LAST);
    stat.sendLast = (sendCnt == SEND_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetId <= '0;
      sendCnt  <= '0;
    end else if (strb.loadTarget) begin
      targetId <= reqId;
      sendCnt  <= '0;
    end else if (strb.bumpSend) begin
      sendCnt  <= sendCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            winCnt <= '0;
    else if (strb.clrWin) winCnt <= '0;
    else if (strb.incWin) winCnt <= winCnt + 1'b1;
  end

  // one sticky flag per slave
  for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_dead
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          deadVec[g] <= 1'b0;
      else if (strb.markDead && targetId == ID_W'(g))     deadVec[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      successQ <= 1'b0;
    end else begin
      doneQ <= strb.finishOk || strb.finishFail;
      if (strb.finishOk)        successQ <= 1'b1;
      else if (strb.finishFail) successQ <= 1'b0;
    end
  end

endmodule

// File: rtl/poll_retry_fsm.sv
module poll_retry_fsm
  import poll_retry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         txDone,
  input  dpStatus_t    stat,
  output ctrlStrobes_t strb,
  output phase_e       phase
);

  phase_e phaseNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  always_comb begin
    strb     = '0;
    phaseNxt = phase;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          if (stat.reqDead) begin
            strb.finishFail = 1'b1;
          end else begin
            strb.loadTarget = 1'b1;
            phaseNxt        = PH_LAUNCH;
          end
        end
      end
      PH_LAUNCH: phaseNxt = PH_TXWAIT;
      PH_TXWAIT: begin
        if (txDone) begin
          strb.clrWin = 1'b1;
          phaseNxt    = PH_RSPWAIT;
        end
      end
      PH_RSPWAIT: begin
        if (stat.rspHit) begin
          strb.finishOk = 1'b1;
          phaseNxt      = PH_IDLE;
        end else if (stat.winLast) begin
          if (stat.sendLast) begin
            strb.markDead   = 1'b1;
            strb.finishFail = 1'b1;
            phaseNxt        = PH_IDLE;
          end else begin
            strb.bumpSend = 1'b1;
            phaseNxt      = PH_LAUNCH;
          end
        end else begin
          strb.incWin = 1'b1;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/poll_retry_ctrl.sv
module poll_retry_ctrl
  import poll_retry_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int CLK_HZ    = 100_000_000,
  parameter int WINDOW_US = 2000,
  parameter int MAX_SENDS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ID_W-1:0]      reqId,
  input  logic                 txDone,
  input  logic                 rxValid,
  input  logic [ID_W-1:0]      rxId,
  output logic                 txStart,
  output logic [ID_W-1:0]      txId,
  output logic                 busy,
  output logic                 done,
  output logic                 success,
  output logic [(1<<ID_W)-1:0] deadFlags
);

  localparam longint WIN_PROD = longint'(CLK_HZ) * longint'(WINDOW_US);
  localparam int     WIN_CYC  = int'(WIN_PROD / 64'd1_000_000);

  ctrlStrobes_t strb;
  dpStatus_t    stat;
  phase_e       phase;

  poll_retry_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .txDone   (txDone),
    .stat     (stat),
    .strb     (strb),
    .phase    (phase)
  );

  poll_retry_dp #(
    .ID_W      (ID_W),
    .WIN_CYC   (WIN_CYC),
    .MAX_SENDS (MAX_SENDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqId    (reqId),
    .rxValid  (rxValid),
    .rxId     (rxId),
    .stat     (stat),
    .targetId (txId),
    .deadVec  (deadFlags),
    .doneQ    (done),
    .successQ (success)
  );

  assign txStart = (phase == PH_LAUNCH);
  assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/poll_retry_chk.sv
module poll_retry_chk #(
  parameter int ID_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 txStart,
  input logic [ID_W-1:0]      txId,
  input logic                 busy,
  input logic                 done,
  input logic                 success,
  input logic [(1<<ID_W)-1:0] deadFlags
);

  p_tx_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_ok_after_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && success) |-> $past(busy));

  p_dead_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(deadFlags) & ~deadFlags) == '0));

  p_dead_with_fail_r5: assert property (@(posedge clk) disable iff (!rstN)
    (deadFlags != $past(deadFlags)) |-> (done && !success &&
      $countones(deadFlags & ~$past(deadFlags)) == 1));

  p_no_tx_dead_r6: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !deadFlags[txId]);

endmodule

bind poll_retry_ctrl poll_retry_chk #(.ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txStart   (txStart),
  .txId      (txId),
  .busy      (busy),
  .done      (done),
  .success   (success),
  .deadFlags (deadFlags)
);

// File: tb/tb_poll_retry_ctrl.sv
module tb_poll_retry_ctrl;

  localparam int ID_W      = 3;
  localparam int CLK_HZ    = 25_000;
  localparam int WINDOW_US = 2000;
  localparam int MAX_SENDS = 5;
  localparam int W         = CLK_HZ * WINDOW_US / 1_000_000;
  localparam int NS        = 1 << ID_W;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [ID_W-1:0] reqId = '0;
  logic            txDone = 1'b0;
  logic            rxValid = 1'b0;
  logic [ID_W-1:0] rxId = '0;
  logic            txStart, busy, done, success;
  logic [ID_W-1:0] txId;
  logic [NS-1:0]   deadFlags;

  int checks = 0, failures = 0, txCount = 0;
  bit finished = 1'b0;

  poll_retry_ctrl #(.ID_W(ID_W), .CLK_HZ(CLK_HZ), .WINDOW_US(WINDOW_US),
                    .MAX_SENDS(MAX_SENDS)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId),
    .txDone(txDone), .rxValid(rxValid), .rxId(rxId), .txStart(txStart),
    .txId(txId), .busy(busy), .done(done), .success(success),
    .deadFlags(deadFlags));

  always #5 clk = ~clk;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 launching, 2 awaiting send, 3 window
  int mPhase, mTimer, mTries, mTarget;
  bit mDone, mOk;
  bit [NS-1:0] mDead;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mTimer = 0; mTries = 0; mTarget = 0;
      mDone = 0; mOk = 0; mDead = '0;
    end else begin
      mDone = 0;
      case (mPhase)
        0: if (reqValid) begin
             if (mDead[reqId]) begin mDone = 1; mOk = 0; end
             else begin mTarget = int'(reqId); mTries = 0; mPhase = 1; end
           end
        1: mPhase = 2;
        2: if (txDone) begin mPhase = 3; mTimer = 0; end
        default: begin
          if (rxValid && int'(rxId) == mTarget) begin
            mDone = 1; mOk = 1; mPhase = 0;
          end else if (mTimer == W - 1) begin
            mTries++;
            if (mTries == MAX_SENDS) begin
              mDead[mTarget] = 1'b1; mDone = 1; mOk = 0; mPhase = 0;
            end else mPhase = 1;
          end else mTimer++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (txStart) txCount++;
      check(busy == (mPhase != 0), "R7", "busy", busy, mPhase != 0);
      check(txStart == (mPhase == 1), "R2", "txStart", txStart, mPhase == 1);
      if (mPhase == 1) check(int'(txId) == mTarget, "R4", "txId", txId, mTarget);
      check(done == mDone, "R3", "done", done, mDone);
      if (mDone) check(success == mOk, "R5", "success", success, mOk);
      check(deadFlags == mDead, "R5", "deadFlags", deadFlags, mDead);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(int id);
    reqValid = 1'b1; reqId = ID_W'(id);
    tick(1);
    reqValid = 1'b0;
  endtask

  task automatic reply(int id);
    rxValid = 1'b1; rxId = ID_W'(id);
    tick(1);
    rxValid = 1'b0;
  endtask

  task automatic waitTx();
    for (int g = 0; g < 1000 && !txStart; g++) tick(1);
  endtask

  task automatic finishFrame();
    txDone = 1'b1;
    tick(1);
    txDone = 1'b0;
  endtask

  task automatic sendFrame(int d);
    waitTx();
    tick(d);
    finishFrame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    check(busy == 0 && txStart == 0 && done == 0, "R1", "reset outputs", {busy, txStart, done}, 0);
    check(deadFlags == '0, "R1", "reset deadFlags", deadFlags, 0);
    rstN = 1'b1;
    tick(2);

    // basic success
    request(2);
    check(txStart == 1 && txId == 2, "R2", "launch id", txId, 2);
    sendFrame(2);
    tick(9);
    reply(2);
    check(done && success && !busy, "R3", "success done", {done, success, busy}, 3'b110);

    // wrong-id reply ignored, reply in last window cycle accepted
    tick(2);
    request(3);
    sendFrame(3);
    reply(4);
    check(!done && busy, "R8", "foreign id ignored", done, 0);
    tick(W - 2);
    reply(3);
    check(done && success, "R9", "last-cycle reply", {done, success}, 3);

    // timeout then resend, window length
    tick(2);
    txCount = 0;
    request(5);
    sendFrame(2);
    begin
      int n = 0;
      while (!txStart && n < 10 * W) begin tick(1); n++; end
      check(n == W, "R10", "window cycles", n, W);
    end
    check(txId == 5, "R4", "resend id", txId, 5);
    sendFrame(2);
    tick(5);
    reply(5);
    check(done && success, "R4", "success after resend", {done, success}, 3);
    check(txCount == 2, "R4", "send count", txCount, 2);

    // silent slave declared dead
    tick(2);
    txCount = 0;
    request(6);
    for (int i = 0; i < MAX_SENDS; i++) begin
      sendFrame(2);
      for (int g = 0; g < 10 * W && !txStart && !done; g++) tick(1);
      if (i < MAX_SENDS - 1) check(!done, "R5", "early done", done, 0);
    end
    check(done && !success, "R5", "dead done", {done, success}, 2);
    check(deadFlags[6] == 1'b1, "R5", "dead flag", deadFlags[6], 1);
    check(txCount == MAX_SENDS, "R5", "sends before dead", txCount, MAX_SENDS);

    // request to dead slave
    tick(2);
    txCount = 0;
    request(6);
    check(done && !success && !busy, "R6", "dead request", {done, success, busy}, 3'b100);
    tick(3);
    check(txCount == 0 && !busy, "R6", "no launch to dead", txCount, 0);
    check(deadFlags[6] == 1'b1, "R5", "dead flag sticky", deadFlags[6], 1);

    // request while busy, reply before frame sent
    request(1);
    request(7);
    reply(1);
    check(!done && busy && txId == 1, "R7", "busy request ignored", txId, 1);
    check(!done, "R8", "early reply ignored", done, 0);
    finishFrame();
    tick(3);
    reply(1);
    check(done && success, "R7", "original completes", {done, success}, 3);
    check(txCount == 1, "R7", "single launch", txCount, 1);

    // reply right after window expiry is ignored
    tick(2);
    request(4);
    sendFrame(2);
    tick(W);
    reply(4);
    check(!done && busy, "R9", "late reply ignored", done, 0);
    finishFrame();
    reply(4);
    check(done && success, "R9", "recovered", {done, success}, 3);

    // reset clears dead flags
    tick(2);
    rstN = 1'b0;
    tick(2);
    check(deadFlags == '0 && !busy, "R1", "reset clears dead", deadFlags, 0);
    rstN = 1'b1;
    tick(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule